// File: doc/BRIEF.md
# Micro-op Cache Line Packer

The packer sits between the instruction decoder and the micro-op cache data array. It takes one decoded micro-op per cycle and assembles one 64-byte cache line entry. Each micro-op takes a 56-bit slot placed upward from the bottom of the line. A wide immediate is not kept in the slot. It is split into 32-bit chunks placed downward from the top of the line, so the unused bytes always sit between the two regions.

When an entry closes, the packer presents the packed line for one cycle, together with a slot valid mask, the micro-op count, the chunk count and a 3-bit close reason. An entry closes in four situations:
- the line has no room for the next micro-op,
- a micro-op of a predicted-taken branch arrives,
- the fetch stream moves into a new instruction-cache line while boundary splitting is enabled,
- the entry would go past its cap on immediate chunks or on micro-ops from microcoded instructions (instructions that expand to four or more micro-ops).

A flush drops the partial entry without emitting it.

Top module: `upc_line_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An emitted entry appears on out_* exactly one cycle after the edge that closes it, and lasts one cycle. Micro-op i occupies bits [56*i +: 56] of out_line, in this layout: [55:54] is its chunk count, [53:50] is the index of its first chunk, [49:0] is its payload. Unused bytes are zero. out_mask has bits 0..out_uops-1 set.
- R3: Chunk c occupies bits [512-32*(c+1) +: 32]. The lowest 32 bits of in_imm go into the first chunk of the micro-op, and the next 32 bits go into the following chunk.
- R4: A micro-op needs 7*(n+1)+4*(c+k) bytes, where n and c are the stored micro-op and chunk counts and k is its own chunk count. If that exceeds 64, the current entry is emitted with reason FULL (0) and the micro-op starts a new entry.
- R5: If, after a micro-op is stored, there is no room for a further 7-byte micro-op, the entry is emitted at once with reason FULL (0).
- R6: An accepted micro-op with in_taken set is stored, and the entry is emitted with reason TAKEN (1).
- R7: When split_on_line is 1, an accepted micro-op with in_newline set closes a non-empty entry with reason BOUNDARY (2) before it is stored. When split_on_line is 0, in_newline has no effect.
- R8: If the chunk count would exceed MAX_IMM_CHUNKS, the entry closes before the micro-op with reason IMM_CAP (3).
- R9: If an in_ucode micro-op would bring the microcoded count above MAX_UCODE, the entry closes before it with reason UCODE_CAP (4).
- R10: When several close-before conditions hold at once, the priority is FULL, then BOUNDARY, then IMM_CAP, then UCODE_CAP. Close-before conditions apply only to a non-empty entry.
- R11: Sometimes a close-before and a taken close fall on the same micro-op. The old entry is emitted first, in_ready drops for one cycle, and the one-micro-op entry is emitted in the following cycle with reason TAKEN.
- R12: flush discards the partial entry and any pending entry, ignores in_valid in that cycle, and emits nothing in the following cycle. Reason code 5 (FLUSH) is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the partial entry |
| in_valid | input | 1 | Micro-op present |
| in_ready | output | 1 | Packer can take a micro-op |
| in_payload | input | 50 | Micro-op payload |
| in_imm_cnt | input | 2 | Number of 32-bit immediate chunks (0..3) |
| in_imm | input | 96 | Immediate data, chunk 0 in the low bits |
| in_taken | input | 1 | Micro-op belongs to a predicted-taken branch |
| in_newline | input | 1 | Micro-op starts a new instruction-cache line |
| in_ucode | input | 1 | Micro-op comes from a microcoded instruction |
| split_on_line | input | 1 | Close entries at instruction-cache line crossings |
| out_valid | output | 1 | Emitted entry valid |
| out_line | output | 512 | Packed line |
| out_mask | output | 9 | Slot valid mask |
| out_uops | output | 4 | Micro-op count |
| out_imms | output | 5 | Immediate chunk count |
| out_reason | output | 3 | Close reason |

## Verification
The close-before path and the taken close can hit the same micro-op, which asks for two emissions from one input. The bench provokes this on purpose: it first fills an entry, then sends a taken micro-op that also crosses a line boundary or overflows a cap. Random traffic with frequent taken and boundary flags adds more such cases. The bench judges the result by checking that the old entry is emitted, then that in_ready is low for exactly one cycle, then that a one-slot TAKEN entry follows. A bench model, built from the requirements, predicts every emission cycle by cycle.

// File: rtl/upc_pkg.sv
package upc_pkg;
  localparam int LINE_BYTES  = 64;
  localparam int UOP_BYTES   = 7;
  localparam int CHUNK_BYTES = 4;
  localparam int LINE_W      = LINE_BYTES * 8;
  localparam int UOP_W       = UOP_BYTES * 8;
  localparam int CHUNK_W     = CHUNK_BYTES * 8;
  localparam int MAX_UOPS    = LINE_BYTES / UOP_BYTES;
  localparam int MAX_CHUNKS  = LINE_BYTES / CHUNK_BYTES;
  localparam int KCNT_W      = 2;
  localparam int IMM_MAX_K   = (1 << KCNT_W) - 1;
  localparam int IDX_W       = $clog2(MAX_CHUNKS);
  localparam int PAY_W       = UOP_W - KCNT_W - IDX_W;
  localparam int UCNT_W      = $clog2(MAX_UOPS + 1);
  localparam int CCNT_W      = $clog2(MAX_CHUNKS + 1);
  localparam int IMM_IN_W    = IMM_MAX_K * CHUNK_W;

  typedef enum logic [2:0] {
    END_FULL     = 3'd0,
    END_TAKEN    = 3'd1,
    END_BOUNDARY = 3'd2,
    END_IMM      = 3'd3,
    END_UCODE    = 3'd4,
    END_FLUSH    = 3'd5
  } end_reason_e;

  // Bytes needed once one more micro-op with k chunks is added.
  function automatic int unsigned bytes_needed(int unsigned nu, int unsigned nc, int unsigned k);
    return (nu + 1) * UOP_BYTES + (nc + k) * CHUNK_BYTES;
  endfunction

  function automatic logic [MAX_UOPS-1:0] slot_mask(logic [UCNT_W-1:0] n);
    logic [MAX_UOPS-1:0] m;
    for (int i = 0; i < MAX_UOPS; i++) m[i] = (i < int'(n));
    return m;
  endfunction
endpackage

// File: rtl/upc_space_check.sv
module upc_space_check import upc_pkg::*; (
  input  logic [UCNT_W-1:0] n_uops,
  input  logic [CCNT_W-1:0] n_chunks,
  input  logic [KCNT_W-1:0] add_chunks,
  output logic              fits
);
  assign fits = bytes_needed(int'(n_uops), int'(n_chunks), int'(add_chunks)) <= LINE_BYTES;
endmodule

// File: rtl/upc_close_ctrl.sv
module upc_close_ctrl import upc_pkg::*; #(
  parameter int MAX_IMM_CHUNKS = 8,
  parameter int MAX_UCODE      = 3
) (
  input  logic              accept,
  input  logic [UCNT_W-1:0] n_uops,
  input  logic [CCNT_W-1:0] n_chunks,
  input  logic [UCNT_W-1:0] n_ucode,
  input  logic [KCNT_W-1:0] add_chunks,
  input  logic              fits_now,
  input  logic              room_next,
  input  logic              split_mode,
  input  logic              newline,
  input  logic              ucode,
  input  logic              taken,
  output logic              pre_close,
  output end_reason_e       pre_reason,
  output logic              post_close,
  output end_reason_e       post_reason
);
  logic nonempty, imm_over, uc_over;
  assign nonempty = (n_uops != '0);
  assign imm_over = (int'(n_chunks) + int'(add_chunks)) > MAX_IMM_CHUNKS;
  assign uc_over  = ucode && ((int'(n_ucode) + 1) > MAX_UCODE);

  always_comb begin
    pre_close  = 1'b0;
    pre_reason = END_FULL;
    if (accept && nonempty) begin
      if (!fits_now) begin
        pre_close = 1'b1; pre_reason = END_FULL;
      end else if (split_mode && newline) begin
        pre_close = 1'b1; pre_reason = END_BOUNDARY;
      end else if (imm_over) begin
        pre_close = 1'b1; pre_reason = END_IMM;
      end else if (uc_over) begin
        pre_close = 1'b1; pre_reason = END_UCODE;
      end
    end
    post_close  = 1'b0;
    post_reason = END_FULL;
    if (accept && taken) begin
      post_close = 1'b1; post_reason = END_TAKEN;
    end else if (accept && !room_next) begin
      post_close = 1'b1; post_reason = END_FULL;
    end
  end
endmodule

// File: rtl/upc_slot_writer.sv
module upc_slot_writer import upc_pkg::*; (
  input  logic [LINE_W-1:0]   base,
  input  logic [UCNT_W-1:0]   slot_idx,
  input  logic [CCNT_W-1:0]   chunk_base,
  input  logic [PAY_W-1:0]    payload,
  input  logic [KCNT_W-1:0]   imm_cnt,
  input  logic [IMM_IN_W-1:0] imm,
  output logic [LINE_W-1:0]   line_out
);
  logic [UOP_W-1:0] slot;
  assign slot = {imm_cnt, chunk_base[IDX_W-1:0], payload};

  always_comb begin
    line_out = base;
    for (int s = 0; s < MAX_UOPS; s++)
      if (int'(slot_idx) == s) line_out[s*UOP_W +: UOP_W] = slot;
    for (int c = 0; c < MAX_CHUNKS; c++)
      for (int j = 0; j < IMM_MAX_K; j++)
        if (j < int'(imm_cnt) && c == int'(chunk_base) + j)
          line_out[LINE_W - CHUNK_W*(c+1) +: CHUNK_W] = imm[j*CHUNK_W +: CHUNK_W];
  end
endmodule

// File: rtl/upc_line_packer.sv
module upc_line_packer import upc_pkg::*; #(
  parameter int MAX_IMM_CHUNKS = 8,
  parameter int MAX_UCODE      = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [PAY_W-1:0]    in_payload,
  input  logic [KCNT_W-1:0]   in_imm_cnt,
  input  logic [IMM_IN_W-1:0] in_imm,
  input  logic                in_taken,
  input  logic                in_newline,
  input  logic                in_ucode,
  input  logic                split_on_line,
  output logic                out_valid,
  output logic [LINE_W-1:0]   out_line,
  output logic [MAX_UOPS-1:0] out_mask,
  output logic [UCNT_W-1:0]   out_uops,
  output logic [CCNT_W-1:0]   out_imms,
  output logic [2:0]          out_reason
);
  logic [LINE_W-1:0] line_q;
  logic [UCNT_W-1:0] nu_q, nuc_q;
  logic [CCNT_W-1:0] nc_q;
  logic              pend_q;

  logic accept, fits_now, room_next, pre_close, post_close;
  end_reason_e pre_reason, post_reason;

  logic [LINE_W-1:0] base_line, new_line;
  logic [UCNT_W-1:0] nu_b, nuc_b, nu_n, nuc_n;
  logic [CCNT_W-1:0] nc_b, nc_n;

  logic              emit_go;
  logic [LINE_W-1:0] emit_line;
  logic [UCNT_W-1:0] emit_nu;
  logic [CCNT_W-1:0] emit_nc;
  end_reason_e       emit_reason;

  assign in_ready = !pend_q;
  assign accept   = in_valid && in_ready && !flush;

  upc_space_check u_fit (
    .n_uops(nu_q), .n_chunks(nc_q), .add_chunks(in_imm_cnt), .fits(fits_now));

  assign base_line = pre_close ? '0 : line_q;
  assign nu_b      = pre_close ? '0 : nu_q;
  assign nc_b      = pre_close ? '0 : nc_q;
  assign nuc_b     = pre_close ? '0 : nuc_q;
  assign nu_n      = nu_b + 1'b1;
  assign nc_n      = nc_b + CCNT_W'(in_imm_cnt);
  assign nuc_n     = nuc_b + UCNT_W'(in_ucode);

  upc_slot_writer u_wr (
    .base(base_line), .slot_idx(nu_b), .chunk_base(nc_b), .payload(in_payload),
    .imm_cnt(in_imm_cnt), .imm(in_imm), .line_out(new_line));

  upc_space_check u_room (
    .n_uops(nu_n), .n_chunks(nc_n), .add_chunks('0), .fits(room_next));

  upc_close_ctrl #(.MAX_IMM_CHUNKS(MAX_IMM_CHUNKS), .MAX_UCODE(MAX_UCODE)) u_ctl (
    .accept(accept), .n_uops(nu_q), .n_chunks(nc_q), .n_ucode(nuc_q),
    .add_chunks(in_imm_cnt), .fits_now(fits_now), .room_next(room_next),
    .split_mode(split_on_line), .newline(in_newline), .ucode(in_ucode), .taken(in_taken),
    .pre_close(pre_close), .pre_reason(pre_reason),
    .post_close(post_close), .post_reason(post_reason));

  always_comb begin
    emit_go     = 1'b0;
    emit_line   = line_q;
    emit_nu     = nu_q;
    emit_nc     = nc_q;
    emit_reason = END_FULL;
    if (!flush) begin
      if (pend_q) begin
        emit_go = 1'b1; emit_reason = END_TAKEN;
      end else if (pre_close) begin
        emit_go = 1'b1; emit_reason = pre_reason;
      end else if (post_close) begin
        emit_go = 1'b1; emit_line = new_line; emit_nu = nu_n; emit_nc = nc_n;
        emit_reason = post_reason;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0; nu_q <= '0; nc_q <= '0; nuc_q <= '0; pend_q <= 1'b0;
      out_valid <= 1'b0; out_line <= '0; out_mask <= '0;
      out_uops <= '0; out_imms <= '0; out_reason <= END_FULL;
    end else begin
      out_valid <= emit_go;
      if (emit_go) begin
        out_line   <= emit_line;
        out_mask   <= slot_mask(emit_nu);
        out_uops   <= emit_nu;
        out_imms   <= emit_nc;
        out_reason <= emit_reason;
      end
      if (flush || pend_q || (accept && post_close && !pre_close)) begin
        line_q <= '0; nu_q <= '0; nc_q <= '0; nuc_q <= '0; pend_q <= 1'b0;
      end else if (accept) begin
        line_q <= new_line; nu_q <= nu_n; nc_q <= nc_n; nuc_q <= nuc_n;
        pend_q <= post_close;
      end
    end
  end
endmodule

// File: rtl/upc_line_packer_chk.sv
module upc_line_packer_chk import upc_pkg::*; #(
  parameter int MAX_IMM_CHUNKS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_taken,
  input logic                out_valid,
  input logic [MAX_UOPS-1:0] out_mask,
  input logic [UCNT_W-1:0]   out_uops,
  input logic [CCNT_W-1:0]   out_imms,
  input logic [2:0]          out_reason,
  input logic                pre_close,
  input logic                post_close
);
  assert_mask_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) == int'(out_uops)) && (out_uops != '0)
                  && ((out_mask & (out_mask + 1'b1)) == '0));

  assert_space_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_uops) * UOP_BYTES + int'(out_imms) * CHUNK_BYTES) <= LINE_BYTES);

  assert_imm_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_imms) <= MAX_IMM_CHUNKS);

  assert_taken_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_taken && !flush) |=> out_valid);

  assert_double_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_close && post_close) |=> (out_valid && !in_ready));

  assert_stall_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  assert_flush_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  assert_no_flush_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_reason != 3'd5);
endmodule

bind upc_line_packer upc_line_packer_chk #(.MAX_IMM_CHUNKS(MAX_IMM_CHUNKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
  .in_taken(in_taken), .out_valid(out_valid), .out_mask(out_mask), .out_uops(out_uops),
  .out_imms(out_imms), .out_reason(out_reason), .pre_close(pre_close),
  .post_close(post_close));

// File: tb/upc_line_packer_test.sv
`timescale 1ns/1ps
module upc_line_packer_test;
  localparam int MAXI = 8;
  localparam int MAXU = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, in_valid = 0, in_taken = 0, in_newline = 0, in_ucode = 0, mode = 0;
  logic [49:0] in_payload = '0;
  logic [1:0]  in_imm_cnt = '0;
  logic [95:0] in_imm = '0;
  logic in_ready, out_valid;
  logic [511:0] out_line;
  logic [8:0] out_mask;
  logic [3:0] out_uops;
  logic [4:0] out_imms;
  logic [2:0] out_reason;

  always #2 clk = ~clk;

  upc_line_packer #(.MAX_IMM_CHUNKS(MAXI), .MAX_UCODE(MAXU)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .in_imm_cnt(in_imm_cnt), .in_imm(in_imm), .in_taken(in_taken),
    .in_newline(in_newline), .in_ucode(in_ucode), .split_on_line(mode),
    .out_valid(out_valid), .out_line(out_line), .out_mask(out_mask), .out_uops(out_uops),
    .out_imms(out_imms), .out_reason(out_reason));

  int nchk = 0, nfail = 0;
  string tag = "R1";

  // bench model state
  logic [511:0] m_line = '0;
  int m_nu = 0, m_nc = 0, m_uc = 0;
  bit m_pend = 0;
  bit e_v = 0;
  logic [511:0] e_line;
  int e_nu, e_nc, e_rs;

  function automatic void m_emit(int rs);
    e_v = 1; e_line = m_line; e_nu = m_nu; e_nc = m_nc; e_rs = rs;
  endfunction
  function automatic void m_clear();
    m_line = '0; m_nu = 0; m_nc = 0; m_uc = 0;
  endfunction

  function automatic void model(bit v, bit fl, bit tk, bit nl, bit uc, int k,
                                logic [49:0] pay, logic [95:0] imm);
    int pre;
    e_v = 0;
    if (fl) begin m_clear(); m_pend = 0; return; end
    if (m_pend) begin m_emit(1); m_clear(); m_pend = 0; return; end
    if (!v) return;
    pre = -1;
    if (m_nu > 0) begin
      if (7*(m_nu+1) + 4*(m_nc+k) > 64) pre = 0;
      else if (mode && nl) pre = 2;
      else if (m_nc + k > MAXI) pre = 3;
      else if (uc && m_uc + 1 > MAXU) pre = 4;
    end
    if (pre >= 0) begin m_emit(pre); m_clear(); end
    m_line[56*m_nu +: 56] = {k[1:0], m_nc[3:0], pay};
    for (int j = 0; j < k; j++) m_line[512 - 32*(m_nc+j+1) +: 32] = imm[32*j +: 32];
    m_nu++; m_nc += k; m_uc += int'(uc);
    if (tk) begin
      if (pre >= 0) m_pend = 1; else begin m_emit(1); m_clear(); end
    end else if (7*m_nu + 4*m_nc + 7 > 64) begin
      m_emit(0); m_clear();
    end
  endfunction

  task automatic compare();
    nchk++;
    if (in_ready !== !m_pend) begin
      nfail++;
      $display("FAIL %s in_ready actual %0b expected %0b", tag, in_ready, !m_pend);
    end
    nchk++;
    if (out_valid !== e_v) begin
      nfail++;
      $display("FAIL %s out_valid actual %0b expected %0b", tag, out_valid, e_v);
    end else if (e_v && (out_line !== e_line || int'(out_uops) != e_nu ||
             int'(out_imms) != e_nc || int'(out_reason) != e_rs ||
             out_mask !== 9'((1 << e_nu) - 1))) begin
      nfail++;
      $display("FAIL %s entry actual uops=%0d imms=%0d reason=%0d mask=%h line=%h expected uops=%0d imms=%0d reason=%0d line=%h",
               tag, out_uops, out_imms, out_reason, out_mask, out_line, e_nu, e_nc, e_rs, e_line);
    end
  endtask

  task automatic step(bit v, bit fl, bit tk, bit nl, bit uc, int k);
    logic [49:0] pay;
    logic [95:0] imm;
    pay = {$urandom, $urandom};
    imm = {$urandom, $urandom, $urandom};
    compare();
    in_valid = v; flush = fl; in_taken = tk; in_newline = nl; in_ucode = uc;
    in_imm_cnt = 2'(k); in_payload = pay; in_imm = imm;
    model(v, fl, tk, nl, uc, k, pay, imm);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic uop(int k, bit tk = 0, bit nl = 0, bit uc = 0);
    step(1, 0, tk, nl, uc, k);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1"; compare();                         // reset state

    tag = "R2 R3"; uop(0); uop(2); uop(1); uop(3, 1); idle(2);
    tag = "R4"; for (int i = 0; i < 6; i++) uop(1); uop(0, 1); idle(2);
    tag = "R5"; for (int i = 0; i < 9; i++) uop(0); idle(2);
    tag = "R7"; mode = 1; uop(0); uop(1); uop(0, 0, 1); uop(0, 1); idle(1);
    mode = 0; uop(0); uop(0, 0, 1); uop(0, 1); idle(2);
    tag = "R8"; uop(3); uop(3); uop(3); uop(0, 1); idle(2);
    tag = "R9"; for (int i = 0; i < 4; i++) uop(0, 0, 0, 1); uop(0, 1); idle(2);
    tag = "R10"; mode = 1; for (int i = 0; i < 5; i++) uop(1); uop(1, 0, 1); uop(0, 1);
    uop(3); uop(3); uop(3, 0, 1); uop(0, 1); idle(2);
    tag = "R11"; uop(0); uop(0); uop(2, 1, 1); uop(0); uop(0, 1); idle(2);
    tag = "R12"; uop(1); uop(2); step(1, 1, 1, 0, 0, 1); uop(0, 1); idle(1);
    uop(0); uop(0, 1, 1); step(0, 1, 0, 0, 0, 0); idle(2);

    tag = "R4 R5 R6 R7 R8 R9 R11 R12 random";
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) mode = $urandom % 2;
      step(($urandom % 10) < 8, ($urandom % 50) == 0, ($urandom % 10) == 0,
           ($urandom % 7) == 0, ($urandom % 6) == 0, $urandom % 4);
    end
    idle(3);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule